// File: doc/BRIEF.md
# SCSI Initiator Programmed-I/O Phase Engine

This block is the initiator-side engine that moves single bytes across a SCSI bus with the REQ/ACK handshake during the non-data phases: command, message-out, status and message-in. A controller hands it a transfer request made of an expected phase, a direction and a byte count. For each byte the engine waits for the target's REQ and compares the bus phase lines with the expected phase. It then completes the handshake and either takes the byte from the controller's write port or hands it to the controller's read port. DMA data phases are not handled here.

A composite collect-status request reads status bytes for as long as the target stays in the status phase. When the target moves to message-in, the engine reads one message byte and reports whether the command completed cleanly. Every request ends with a one-cycle `done` pulse and an outcome code. A pulse on `reset_req` tells the controller that the bus should be reset.

Top module: `scsi_pio_engine`

## Requirements
- R1: The phase encoding is {MSG, C/D, I/O} in bits 2..0. Output requests (`req_dir`=0) accept only command (010) and message-out (110). Input requests (`req_dir`=1) accept only status (011) and message-in (111). Any other pair ends on the clock after acceptance with code 4 (bad request), and the bus is not touched.
- R2: If REQ is not seen within TMO_CYC cycles, or is not released within TMO_CYC cycles of ACK, the transfer ends with code 1 (timeout). `reset_req` pulses together with `done` only when the transfer is an output.
- R3: The phase is compared when REQ is first seen. A mismatch while expecting message-out or status ends the transfer with code 2 and no reset request. A mismatch while expecting command or message-in ends it with code 3 and a pulse on `reset_req`. No ACK is given on a mismatch.
- R4: For an output byte, the engine places the byte on `bus_dout` and raises `bus_oe` at least one cycle before it raises `ini_ack`. It holds both until REQ falls, then releases ACK and the drivers together.
- R5: For an input byte, the engine latches `bus_din` when REQ is seen, holds `ini_ack` until REQ falls, and then offers the byte on `rd_data` with `rd_valid` until `rd_ready`.
- R6: A plain request moves exactly `req_count` bytes in order and ends with code 0 (ok). A count of zero ends with code 0 on the clock after acceptance, with no handshake.
- R7: In collect mode (`req_collect`=1, phase and direction ignored), status bytes are read until REQ arrives with a non-status phase. The first STAT_KEEP bytes appear in `stat_bytes`, byte i at bits 8i+7..8i, and unused slots read zero. `stat_count` counts every status byte and saturates at its maximum.
- R8: After the status bytes, collect mode reads one message-in byte and ends with code 0. `cmd_good` is 1 only when that byte is 0x00. A mismatch in that message-in byte gives code 3 with a reset request.
- R9: `exp_phase` shows the expected phase while a transfer is in progress and reads 000 whenever the engine is idle, including after any outcome. `req_ready` is 1 exactly when the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Engine idle, request accepted |
| req_phase | input | 3 | Expected phase {MSG,C/D,I/O} |
| req_dir | input | 1 | 0 = initiator sends, 1 = initiator receives |
| req_collect | input | 1 | Collect-status composite mode |
| req_count | input | CNT_W | Number of bytes for a plain request |
| wr_valid | input | 1 | Controller byte available to send |
| wr_ready | output | 1 | Engine takes the write byte |
| wr_data | input | 8 | Byte to send |
| rd_valid | output | 1 | Received byte available |
| rd_ready | input | 1 | Controller takes the received byte |
| rd_data | output | 8 | Received byte |
| tgt_req | input | 1 | REQ from target |
| ini_ack | output | 1 | ACK to target |
| bus_phase | input | 3 | Bus phase lines {MSG,C/D,I/O} |
| bus_din | input | 8 | Data bus as received |
| bus_dout | output | 8 | Data bus value to drive |
| bus_oe | output | 1 | Data bus driver enable |
| exp_phase | output | 3 | Expected phase setting, zero when idle |
| done | output | 1 | One-cycle completion pulse |
| done_code | output | 3 | Outcome: 0 ok, 1 timeout, 2 quiet mismatch, 3 error mismatch, 4 bad request |
| reset_req | output | 1 | Bus reset request, pulses with done |
| cmd_good | output | 1 | Last collect-status message byte was 0x00 |
| stat_count | output | CNT_W | Status bytes seen in the last collect |
| stat_bytes | output | 8*STAT_KEEP | First status bytes kept |

## Verification
In collect mode, the end of status collection and the start of the message-in byte are both set off by the same input: REQ arriving with the message-in phase. In the cycle that REQ is seen, the engine must treat it as the end of status and not as a fault. It must then take that same REQ as the message byte. The bench provokes this by presenting the message-in REQ straight after the last status handshake, with no idle gap. It judges the result by the byte count, the kept bytes, `cmd_good` and an outcome code of 0. A second case has the target switch to a command phase instead. That case checks that the switch is caught as an error mismatch only in the message-in stage.

// File: rtl/scsi_pio_engine.sv
module scsi_pio_engine #(
  parameter int TMO_CYC   = 64,
  parameter int STAT_KEEP = 4,
  parameter int CNT_W     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [2:0]             req_phase,
  input  logic                   req_dir,
  input  logic                   req_collect,
  input  logic [CNT_W-1:0]       req_count,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [7:0]             wr_data,
  output logic                   rd_valid,
  input  logic                   rd_ready,
  output logic [7:0]             rd_data,
  input  logic                   tgt_req,
  output logic                   ini_ack,
  input  logic [2:0]             bus_phase,
  input  logic [7:0]             bus_din,
  output logic [7:0]             bus_dout,
  output logic                   bus_oe,
  output logic [2:0]             exp_phase,
  output logic                   done,
  output logic [2:0]             done_code,
  output logic                   reset_req,
  output logic                   cmd_good,
  output logic [CNT_W-1:0]       stat_count,
  output logic [8*STAT_KEEP-1:0] stat_bytes
);
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam logic [2:0] PH_CMD = 3'b010, PH_MOUT = 3'b110,
                         PH_STAT = 3'b011, PH_MIN = 3'b111;
  localparam logic [2:0] C_OK = 3'd0, C_TMO = 3'd1, C_QUIET = 3'd2,
                         C_ERR = 3'd3, C_BAD = 3'd4;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_WREQ, S_DRIVE, S_ACKW, S_DELIV} st_t;

  st_t              st;
  logic             dir_q, coll_q, stage_q;
  logic [CNT_W-1:0] remain;
  logic [TW-1:0]    tmr;
  logic [7:0]       data_q;
  logic [7:0]       keep [STAT_KEEP];

  logic       fin, frr, legal, match, tmr_hit, quiet, in_status;
  logic [2:0] fcode;

  assign req_ready = (st == S_IDLE);
  assign wr_ready  = (st == S_FETCH);
  assign rd_valid  = (st == S_DELIV);
  assign rd_data   = data_q;
  assign bus_dout  = data_q;
  assign legal     = req_dir ? (req_phase == PH_STAT || req_phase == PH_MIN)
                             : (req_phase == PH_CMD  || req_phase == PH_MOUT);
  assign match     = (bus_phase == exp_phase);
  assign tmr_hit   = (tmr == TW'(TMO_CYC - 1));
  assign quiet     = (exp_phase == PH_MOUT) || (exp_phase == PH_STAT);
  assign in_status = coll_q && !stage_q;

  for (genvar i = 0; i < STAT_KEEP; i++) begin : g_keep
    assign stat_bytes[8*i +: 8] = keep[i];
  end

  always_comb begin
    fin = 1'b0; fcode = C_OK; frr = 1'b0;
    case (st)
      S_IDLE:
        if (req_valid && !req_collect) begin
          if (!legal) begin fin = 1'b1; fcode = C_BAD; end
          else if (req_count == '0) fin = 1'b1;
        end
      S_WREQ:
        if (tgt_req) begin
          if (!match && !in_status) begin
            fin = 1'b1; fcode = quiet ? C_QUIET : C_ERR; frr = !quiet;
          end
        end else if (tmr_hit) begin
          fin = 1'b1; fcode = C_TMO; frr = !dir_q;
        end
      S_ACKW:
        if (!tgt_req) begin
          if (!dir_q && remain == CNT_W'(1)) fin = 1'b1;
          if (dir_q && coll_q && stage_q) fin = 1'b1;
        end else if (tmr_hit) begin
          fin = 1'b1; fcode = C_TMO; frr = !dir_q;
        end
      S_DELIV:
        if (rd_ready && remain == CNT_W'(1)) fin = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; dir_q <= 1'b0; coll_q <= 1'b0; stage_q <= 1'b0;
      remain <= '0; tmr <= '0; data_q <= '0; exp_phase <= '0;
      ini_ack <= 1'b0; bus_oe <= 1'b0; done <= 1'b0; done_code <= C_OK;
      reset_req <= 1'b0; cmd_good <= 1'b0; stat_count <= '0;
      for (int i = 0; i < STAT_KEEP; i++) keep[i] <= '0;
    end else begin
      done      <= fin;
      reset_req <= frr;
      if (fin) done_code <= fcode;
      if (fin) begin
        st <= S_IDLE; exp_phase <= '0; ini_ack <= 1'b0; bus_oe <= 1'b0;
      end else begin
        case (st)
          S_IDLE:
            if (req_valid) begin
              tmr <= '0;
              if (req_collect) begin
                exp_phase <= PH_STAT; dir_q <= 1'b1; coll_q <= 1'b1;
                stage_q <= 1'b0; cmd_good <= 1'b0; stat_count <= '0;
                for (int i = 0; i < STAT_KEEP; i++) keep[i] <= '0;
                st <= S_WREQ;
              end else begin
                exp_phase <= req_phase; dir_q <= req_dir; coll_q <= 1'b0;
                remain <= req_count;
                st <= req_dir ? S_WREQ : S_FETCH;
              end
            end
          S_FETCH:
            if (wr_valid) begin
              data_q <= wr_data; tmr <= '0; st <= S_WREQ;
            end
          S_WREQ:
            if (tgt_req) begin
              tmr <= '0;
              if (!match) begin
                stage_q <= 1'b1; exp_phase <= PH_MIN;
              end else if (!dir_q) begin
                bus_oe <= 1'b1; st <= S_DRIVE;
              end else begin
                data_q <= bus_din; ini_ack <= 1'b1; st <= S_ACKW;
              end
            end else begin
              tmr <= tmr + 1'b1;
            end
          S_DRIVE: begin
            ini_ack <= 1'b1; tmr <= '0; st <= S_ACKW;
          end
          S_ACKW:
            if (!tgt_req) begin
              ini_ack <= 1'b0; bus_oe <= 1'b0; tmr <= '0;
              if (!dir_q) begin
                remain <= remain - 1'b1; st <= S_FETCH;
              end else if (coll_q) begin
                for (int i = 0; i < STAT_KEEP; i++)
                  if (stat_count == CNT_W'(i)) keep[i] <= data_q;
                if (stat_count != CNT_MAX) stat_count <= stat_count + 1'b1;
                st <= S_WREQ;
              end else begin
                st <= S_DELIV;
              end
            end else begin
              tmr <= tmr + 1'b1;
            end
          S_DELIV:
            if (rd_ready) begin
              remain <= remain - 1'b1; tmr <= '0; st <= S_WREQ;
            end
          default: st <= S_IDLE;
        endcase
      end
      if (st == S_ACKW && !tgt_req && coll_q && stage_q) cmd_good <= (data_q == 8'h00);
    end
  end

  AST_BAD_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_code == C_BAD) |-> $past(req_ready)); // R1
  AST_RESET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (done && (done_code == C_ERR || done_code == C_TMO))); // R2
  AST_QUIET_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_code == C_QUIET) |-> !reset_req); // R3
  AST_OE_LEADS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ini_ack) && bus_oe) |-> $past(bus_oe)); // R4
  AST_OE_OUTPUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !dir_q); // R4
  AST_ACK_HELD_FOR_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ini_ack) && !done) |-> !$past(tgt_req)); // R5
  AST_STAT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_count < $past(stat_count)) |-> $past(req_valid && req_ready && req_collect)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ini_ack && !bus_oe && exp_phase == 3'b000)); // R9
endmodule

// File: tb/tb_scsi_pio_engine.sv
module tb_scsi_pio_engine;
  localparam int TMO = 64, KEEP = 4, CW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_dir = 1'b0, req_collect = 1'b0;
  logic [2:0] req_phase = 3'b000;
  logic [CW-1:0] req_count = '0;
  logic wr_valid = 1'b0, rd_ready = 1'b1;
  logic [7:0] wr_data = '0;
  logic tgt_req = 1'b0;
  logic [2:0] bus_phase = 3'b000;
  logic [7:0] bus_din = '0;
  logic req_ready, wr_ready, rd_valid, ini_ack, bus_oe, done, reset_req, cmd_good;
  logic [7:0] rd_data, bus_dout;
  logic [2:0] exp_phase, done_code;
  logic [CW-1:0] stat_count;
  logic [8*KEEP-1:0] stat_bytes;

  always #5 clk = ~clk;

  scsi_pio_engine #(.TMO_CYC(TMO), .STAT_KEEP(KEEP), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_phase(req_phase), .req_dir(req_dir), .req_collect(req_collect),
    .req_count(req_count), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .tgt_req(tgt_req), .ini_ack(ini_ack), .bus_phase(bus_phase), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .exp_phase(exp_phase), .done(done),
    .done_code(done_code), .reset_req(reset_req), .cmd_good(cmd_good),
    .stat_count(stat_count), .stat_bytes(stat_bytes));

  int checks = 0, errors = 0, cyc = 0, done_cnt = 0, ack_cyc = 0;
  int last_code = 0, last_rr = 0, last_good = 0;
  bit busy = 0, lr = 1, pend = 0, bp = 0, lcoll = 0;
  logic [2:0] lphase = '0;
  byte unsigned wq[$];
  byte unsigned got[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle reference model of the idle/busy state and controller ports
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    rd_ready = !bp || (cyc % 3 == 0);
    if (rd_valid && rd_ready) got.push_back(rd_data);
    if (ini_ack) ack_cyc++;
    if (done) begin
      done_cnt++; last_code = done_code; last_rr = reset_req; last_good = cmd_good;
      busy = 0;
    end else if (req_valid && lr) busy = 1;
    if (rst_n) begin
      check(req_ready == !busy, "R9 ready tracks idle", req_ready, !busy);
      if (!busy) check(exp_phase == 3'b000, "R9 phase zero when idle", exp_phase, 0);
      else if (!lcoll) check(exp_phase == lphase, "R9 phase while busy", exp_phase, lphase);
    end
    lr = req_ready;
    if (pend) void'(wq.pop_front());
    wr_valid = wq.size() > 0;
    wr_data  = wq.size() > 0 ? wq[0] : 8'h00;
    pend = wr_valid && wr_ready;
  end

  task automatic launch(input logic [2:0] ph, input logic dir, input logic coll, input int cnt);
    @(negedge clk); #1;
    req_phase = ph; req_dir = dir; req_collect = coll; req_count = CW'(cnt);
    lphase = ph; lcoll = coll; req_valid = 1'b1;
    @(negedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int start);
    int n = 0;
    while (done_cnt == start && n < 1000) begin @(negedge clk); n++; end
    check(done_cnt > start, "done pulse seen", done_cnt, start + 1);
    @(negedge clk);
  endtask

  task automatic tgt_send(input logic [2:0] ph, input logic [7:0] d);
    int n = 0;
    @(negedge clk);
    bus_phase = ph; bus_din = d; tgt_req = 1'b1;
    do begin @(negedge clk); n++; end while (!ini_ack && n < 400);
    tgt_req = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (ini_ack && n < 400);
  endtask

  task automatic tgt_take(input logic [2:0] ph, input logic [7:0] expd);
    int n = 0;
    bit pre = 0;
    logic [7:0] d;
    bit hold;
    @(negedge clk);
    bus_phase = ph; tgt_req = 1'b1;
    do begin
      @(negedge clk); n++;
      if (bus_oe && !ini_ack) pre = 1;
    end while (!ini_ack && n < 400);
    d = bus_dout; hold = bus_oe;
    check(d == expd, "R4 output byte", d, expd);
    check(pre, "R4 drivers on before ACK", pre, 1);
    check(hold, "R4 drivers held with ACK", hold, 1);
    tgt_req = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (ini_ack && n < 400);
    check(!bus_oe, "R4 drivers released with ACK", bus_oe, 0);
  endtask

  task automatic tgt_wrong(input logic [2:0] ph, input int start);
    int n = 0;
    @(negedge clk);
    bus_phase = ph; tgt_req = 1'b1;
    while (done_cnt == start && n < 1000) begin @(negedge clk); n++; end
    tgt_req = 1'b0;
  endtask

  initial begin
    int s, a;
    repeat (3) @(negedge clk);
    // Reset state
    check(req_ready == 1'b1, "R9 reset idle", req_ready, 1);
    check(ini_ack == 1'b0 && bus_oe == 1'b0, "R4 reset bus released", {ini_ack, bus_oe}, 0);
    check(exp_phase == 3'b000, "R9 reset phase", exp_phase, 0);
    check(stat_count == 0 && cmd_good == 0, "R7 reset status", stat_count, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Command phase output, three bytes
    wq.push_back(8'h12); wq.push_back(8'h34); wq.push_back(8'h56);
    s = done_cnt;
    fork
      launch(3'b010, 1'b0, 1'b0, 3);
      begin tgt_take(3'b010, 8'h12); tgt_take(3'b010, 8'h34); tgt_take(3'b010, 8'h56); end
    join
    wait_done(s);
    check(last_code == 0 && last_rr == 0, "R6 three-byte command ok", last_code, 0);

    // Message-out single byte
    wq.push_back(8'hC0);
    s = done_cnt;
    fork
      launch(3'b110, 1'b0, 1'b0, 1);
      tgt_take(3'b110, 8'hC0);
    join
    wait_done(s);
    check(last_code == 0, "R6 message-out ok", last_code, 0);

    // Message-in input, two bytes with read backpressure
    got.delete(); bp = 1;
    s = done_cnt;
    fork
      launch(3'b111, 1'b1, 1'b0, 2);
      begin tgt_send(3'b111, 8'hA5); tgt_send(3'b111, 8'h3C); end
    join
    wait_done(s);
    bp = 0;
    check(got.size() == 2, "R5 input byte count", got.size(), 2);
    if (got.size() == 2) begin
      check(got[0] == 8'hA5, "R5 first input byte", got[0], 8'hA5);
      check(got[1] == 8'h3C, "R5 second input byte", got[1], 8'h3C);
    end
    check(last_code == 0, "R5 input ok", last_code, 0);

    // Illegal phase/direction pairs
    a = ack_cyc; s = done_cnt;
    launch(3'b011, 1'b0, 1'b0, 1); wait_done(s);
    check(last_code == 4 && last_rr == 0, "R1 status as output rejected", last_code, 4);
    s = done_cnt;
    launch(3'b010, 1'b1, 1'b0, 1); wait_done(s);
    check(last_code == 4, "R1 command as input rejected", last_code, 4);
    s = done_cnt;
    launch(3'b000, 1'b0, 1'b0, 1); wait_done(s);
    check(last_code == 4, "R1 data phase rejected", last_code, 4);
    check(ack_cyc == a, "R1 no ACK on rejection", ack_cyc - a, 0);

    // Zero count
    s = done_cnt;
    launch(3'b010, 1'b0, 1'b0, 0); wait_done(s);
    check(last_code == 0 && ack_cyc == a, "R6 zero count", last_code, 0);

    // Timeouts
    wq.push_back(8'h77);
    s = done_cnt;
    launch(3'b110, 1'b0, 1'b0, 1); wait_done(s);
    check(last_code == 1 && last_rr == 1, "R2 output timeout resets", {last_code, last_rr}, 8'h11);
    s = done_cnt;
    launch(3'b011, 1'b1, 1'b0, 1); wait_done(s);
    check(last_code == 1 && last_rr == 0, "R2 input timeout no reset", {last_code, last_rr}, 8'h10);

    // Phase mismatches
    wq.push_back(8'h01);
    a = ack_cyc; s = done_cnt;
    fork launch(3'b110, 1'b0, 1'b0, 1); tgt_wrong(3'b111, s); join
    wait_done(s);
    check(last_code == 2 && last_rr == 0, "R3 message-out mismatch quiet", {last_code, last_rr}, 8'h20);
    s = done_cnt;
    fork launch(3'b011, 1'b1, 1'b0, 1); tgt_wrong(3'b111, s); join
    wait_done(s);
    check(last_code == 2 && last_rr == 0, "R3 status mismatch quiet", {last_code, last_rr}, 8'h20);
    wq.push_back(8'h02);
    s = done_cnt;
    fork launch(3'b010, 1'b0, 1'b0, 1); tgt_wrong(3'b011, s); join
    wait_done(s);
    check(last_code == 3 && last_rr == 1, "R3 command mismatch error", {last_code, last_rr}, 8'h31);
    s = done_cnt;
    fork launch(3'b111, 1'b1, 1'b0, 1); tgt_wrong(3'b011, s); join
    wait_done(s);
    check(last_code == 3 && last_rr == 1, "R3 message-in mismatch error", {last_code, last_rr}, 8'h31);
    check(ack_cyc == a, "R3 no ACK on mismatch", ack_cyc - a, 0);

    // Collect status: six bytes, good completion
    s = done_cnt;
    fork
      launch(3'b000, 1'b0, 1'b1, 0);
      begin
        for (int i = 1; i <= 6; i++) tgt_send(3'b011, 8'(i * 16 + i));
        tgt_send(3'b111, 8'h00);
      end
    join
    wait_done(s);
    check(last_code == 0, "R8 collect ok", last_code, 0);
    check(stat_count == 6, "R7 all status bytes counted", stat_count, 6);
    check(stat_bytes == 32'h44332211, "R7 first bytes kept", stat_bytes, 32'h44332211);
    check(last_good == 1 && cmd_good == 1, "R8 command complete", cmd_good, 1);

    // Collect status: one byte, non-zero message
    s = done_cnt;
    fork
      launch(3'b000, 1'b0, 1'b1, 0);
      begin tgt_send(3'b011, 8'h02); tgt_send(3'b111, 8'h04); end
    join
    wait_done(s);
    check(stat_count == 1, "R7 single status count", stat_count, 1);
    check(stat_bytes == 32'h00000002, "R7 unused slots zero", stat_bytes, 32'h2);
    check(cmd_good == 0 && last_code == 0, "R8 other message not good", cmd_good, 0);

    // Collect status: no status bytes, straight to message-in
    s = done_cnt;
    fork
      launch(3'b000, 1'b0, 1'b1, 0);
      tgt_send(3'b111, 8'h00);
    join
    wait_done(s);
    check(stat_count == 0 && cmd_good == 1, "R7 R8 empty status", stat_count, 0);

    // Collect status: target leaves status for command phase
    s = done_cnt;
    fork
      launch(3'b000, 1'b0, 1'b1, 0);
      begin tgt_send(3'b011, 8'h08); tgt_wrong(3'b010, s); end
    join
    wait_done(s);
    check(last_code == 3 && last_rr == 1, "R8 message stage mismatch", {last_code, last_rr}, 8'h31);
    check(cmd_good == 0, "R8 not good after mismatch", cmd_good, 0);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule